// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Unit

This unit sits between the interrupt source controllers of a chip and one processor's external interrupt input. It holds a single pending interrupt and compares it against the processor's current priority and a software-written inter-processor interrupt (IPI) priority. A pending interrupt displaced by a more favored one goes back to its source as a reject. A request that loses arbitration is rejected to its source in the same way.

The processor works the unit through single-cycle register operations: accept, poll, write of the current priority, write of the IPI priority, and end-of-interrupt. The 32-bit presentation register is always visible on `regOut`, and the IPI priority is always visible on `ipiOut`. An accept or poll therefore returns the value present in the cycle the operation is issued. Reject, EOI-forward and resend notifications are single-cycle pulses in the cycle of the operation or request that causes them. State changes take effect at the next rising clock edge.

Top module: `intpres_top`

## Requirements
- R1: After reset, `regOut` is 0, `ipiOut` is 0xFF, `cpuIrq` is low, and no notification pulse is active.
- R2: `regOut` carries the current processor priority in bits 31:24 and the pending source number in bits 23:0. Source 0 means nothing is pending. A lower priority value is more favored, and 0xFF is least favored. `cpuIrq` is high exactly while a source is pending.
- R3: A request (`reqValid`, with `opValid` low) is refused when its priority is greater than or equal to the current priority, or when an interrupt is already pending at a priority less than or equal to the request's. A refused request pulses `rejValid` with `rejSrc` equal to the request's source, and the state is left unchanged.
- R4: A request that is not refused replaces the pending interrupt. If the displaced interrupt came from a source, that source is rejected in the same cycle. The new source and priority are latched, and `cpuIrq` goes high after the edge.
- R5: Accept (opcode 0) lowers `cpuIrq`, clears the source field, moves the pending priority into the current priority, and makes the pending priority 0xFF.
- R6: Set-current-priority (opcode 2, value in `opData[31:24]`) loads the current priority. If the new value is more favored than the old one and at or below the pending priority, the pending interrupt is dropped and rejected to its source if it has one. If the new value is not more favored and nothing is pending, a resend occurs.
- R7: Set-IPI-priority (opcode 3, value in `opData[7:0]`) loads the IPI priority. When the new value is below the current priority and no pending interrupt is at or below it, an IPI with source number 2 and the IPI priority becomes pending. Any sourced interrupt it displaces is rejected. An IPI has no owning source, so a later displacement or drop of it produces no reject.
- R8: End-of-interrupt (opcode 4) loads the current priority from `opData[31:24]`. In the same cycle it pulses `eoiValid` with `eoiSrc` equal to `opData[23:0]`. If nothing is pending, it then performs a resend.
- R9: Poll (opcode 1) changes no state. `regOut` and `ipiOut` give the register and the IPI priority.
- R10: A resend pulses `resendReq`. If the IPI priority is below the current priority that results from the operation, it first presents the IPI. All notification pulses occur only in the cycle of their cause, and at most one reject is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Presentation request from a source controller |
| reqSrc | input | SRC_W | Source number of the request (nonzero) |
| reqPrio | input | PRIO_W | Priority of the request |
| opValid | input | 1 | Processor register operation strobe (never together with reqValid) |
| opCode | input | 3 | 0 accept, 1 poll, 2 set current priority, 3 set IPI priority, 4 end-of-interrupt |
| opData | input | PRIO_W+SRC_W | Operation operand |
| cpuIrq | output | 1 | Interrupt line to the processor |
| regOut | output | PRIO_W+SRC_W | Presentation register: current priority and pending source |
| ipiOut | output | PRIO_W | IPI priority register |
| rejValid | output | 1 | Reject notification pulse |
| rejSrc | output | SRC_W | Source being rejected |
| eoiValid | output | 1 | End-of-interrupt forward pulse |
| eoiSrc | output | SRC_W | Source the EOI is forwarded to |
| resendReq | output | 1 | Pulse asking all sources to resend refused interrupts |

## Verification
The assertions check the invariants that must hold on every cycle. These are: the interrupt line follows the pending source field, an empty slot carries the least favored pending priority, at most one pending-slot update happens per cycle, a granted request or an accept lands in the state at the next edge, and requests never coincide with operations. Other properties need a reference model over long operation sequences. These include arbitration ordering, which source receives a reject, the chain from resend to IPI check when a priority is relaxed or an EOI is written, and the absence of rejects for IPIs. The bench shows these by running directed openings and a long pseudo-random sweep over small priority and source ranges, compared cycle by cycle with a behavioural model.

// File: rtl/intpres_pkg.sv
package intpres_pkg;

  typedef enum logic [2:0] {
    OP_ACCEPT  = 3'd0,
    OP_POLL    = 3'd1,
    OP_SETCPPR = 3'd2,
    OP_SETIPI  = 3'd3,
    OP_EOI     = 3'd4
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ldCppr;        // load current priority
    logic cpprFromPend;  // current priority source: pending priority (else operand)
    logic clrPend;       // empty the pending slot
    logic ldReq;         // latch incoming request
    logic ldIpi;         // latch IPI
    logic ldMfrr;        // load IPI priority
  } dpCtl_t;

endpackage

// File: rtl/intpres_ctrl.sv
module intpres_ctrl
  import intpres_pkg::*;
#(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8,
  localparam int REG_W = PRIO_W + SRC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [SRC_W-1:0]  reqSrc,
  input  logic [PRIO_W-1:0] reqPrio,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [REG_W-1:0]  opData,
  input  logic [PRIO_W-1:0] cppr,
  input  logic [SRC_W-1:0]  xisr,
  input  logic [PRIO_W-1:0] pendPrio,
  input  logic [PRIO_W-1:0] mfrr,
  input  logic              ownerValid,
  output dpCtl_t            ctl,
  output logic              rejValid,
  output logic [SRC_W-1:0]  rejSrc,
  output logic              eoiValid,
  output logic [SRC_W-1:0]  eoiSrc,
  output logic              resendReq
);

  opKind_e op;
  logic [PRIO_W-1:0] opPrio;
  logic [PRIO_W-1:0] opMfrr;
  logic pend;
  logic ipiGo;

  assign op     = opKind_e'(opCode);
  assign opPrio = opData[REG_W-1 -: PRIO_W];
  assign opMfrr = opData[PRIO_W-1:0];
  assign pend   = (xisr != '0);

  always_comb begin
    ctl       = '0;
    rejValid  = 1'b0;
    rejSrc    = '0;
    eoiValid  = 1'b0;
    eoiSrc    = '0;
    resendReq = 1'b0;
    ipiGo     = 1'b0;
    if (opValid) begin
      unique case (op)
        OP_ACCEPT: begin
          ctl.ldCppr       = 1'b1;
          ctl.cpprFromPend = 1'b1;
          ctl.clrPend      = 1'b1;
        end
        OP_SETCPPR: begin
          ctl.ldCppr = 1'b1;
          if (opPrio < cppr) begin
            if (pend && (opPrio <= pendPrio)) begin
              ctl.clrPend = 1'b1;
              rejValid    = ownerValid;
              rejSrc      = xisr;
            end
          end else if (!pend) begin
            resendReq = 1'b1;
            ipiGo     = (mfrr < opPrio);
          end
        end
        OP_SETIPI: begin
          ctl.ldMfrr = 1'b1;
          if ((opMfrr < cppr) && !(pend && (pendPrio <= opMfrr))) begin
            ipiGo    = 1'b1;
            rejValid = pend && ownerValid;
            rejSrc   = xisr;
          end
        end
        OP_EOI: begin
          ctl.ldCppr = 1'b1;
          eoiValid   = 1'b1;
          eoiSrc     = opData[SRC_W-1:0];
          if (!pend) begin
            resendReq = 1'b1;
            ipiGo     = (mfrr < opPrio);
          end
        end
        default: ;  // poll: observation only
      endcase
    end else if (reqValid) begin
      if ((reqPrio >= cppr) || (pend && (pendPrio <= reqPrio))) begin
        rejValid = 1'b1;
        rejSrc   = reqSrc;
      end else begin
        ctl.ldReq = 1'b1;
        rejValid  = pend && ownerValid;
        rejSrc    = xisr;
      end
    end
    ctl.ldIpi = ipiGo;
  end

  // R10: one pending-slot update per cycle
  assert_slot_update_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.clrPend, ctl.ldReq, ctl.ldIpi}));

  // R3: interface contract, requests never share a cycle with an operation
  assert_no_req_during_op_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && opValid));

endmodule

// File: rtl/intpres_dp.sv
module intpres_dp
  import intpres_pkg::*;
#(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8,
  parameter int IPI_SRC = 2,
  localparam int REG_W = PRIO_W + SRC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [SRC_W-1:0]  reqSrc,
  input  logic [PRIO_W-1:0] reqPrio,
  input  logic [REG_W-1:0]  opData,
  output logic [PRIO_W-1:0] cppr,
  output logic [SRC_W-1:0]  xisr,
  output logic [PRIO_W-1:0] pendPrio,
  output logic [PRIO_W-1:0] mfrr,
  output logic              ownerValid,
  output logic              cpuIrq
);

  localparam logic [PRIO_W-1:0] PRIO_NONE = {PRIO_W{1'b1}};
  localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

  logic [PRIO_W-1:0] opPrio;
  logic [PRIO_W-1:0] ipiPrio;

  assign opPrio  = opData[REG_W-1 -: PRIO_W];
  assign ipiPrio = ctl.ldMfrr ? opData[PRIO_W-1:0] : mfrr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cppr       <= '0;
      xisr       <= '0;
      pendPrio   <= PRIO_NONE;
      mfrr       <= PRIO_NONE;
      ownerValid <= 1'b0;
      cpuIrq     <= 1'b0;
    end else begin
      if (ctl.ldCppr) cppr <= ctl.cpprFromPend ? pendPrio : opPrio;
      if (ctl.ldMfrr) mfrr <= opData[PRIO_W-1:0];
      if (ctl.clrPend) begin
        xisr       <= '0;
        pendPrio   <= PRIO_NONE;
        ownerValid <= 1'b0;
        cpuIrq     <= 1'b0;
      end else if (ctl.ldIpi) begin
        xisr       <= IPI_NUM;
        pendPrio   <= ipiPrio;
        ownerValid <= 1'b0;
        cpuIrq     <= 1'b1;
      end else if (ctl.ldReq) begin
        xisr       <= reqSrc;
        pendPrio   <= reqPrio;
        ownerValid <= 1'b1;
        cpuIrq     <= 1'b1;
      end
    end
  end

  assert_irq_tracks_pending_R2: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq == (xisr != '0));

  assert_empty_slot_prio_R5: assert property (@(posedge clk) disable iff (!rstN)
    (xisr == '0) |-> (pendPrio == PRIO_NONE && !ownerValid));

  assert_req_latch_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldReq |=> (xisr == $past(reqSrc) && pendPrio == $past(reqPrio) && ownerValid));

  assert_accept_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cpprFromPend |=> (xisr == '0 && !cpuIrq && cppr == $past(pendPrio)));

endmodule

// File: rtl/intpres_top.sv
module intpres_top
  import intpres_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2,
  localparam int REG_W  = PRIO_W + SRC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [SRC_W-1:0]  reqSrc,
  input  logic [PRIO_W-1:0] reqPrio,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [REG_W-1:0]  opData,
  output logic              cpuIrq,
  output logic [REG_W-1:0]  regOut,
  output logic [PRIO_W-1:0] ipiOut,
  output logic              rejValid,
  output logic [SRC_W-1:0]  rejSrc,
  output logic              eoiValid,
  output logic [SRC_W-1:0]  eoiSrc,
  output logic              resendReq
);

  dpCtl_t            ctl;
  logic [PRIO_W-1:0] cppr;
  logic [SRC_W-1:0]  xisr;
  logic [PRIO_W-1:0] pendPrio;
  logic [PRIO_W-1:0] mfrr;
  logic              ownerValid;

  intpres_ctrl #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqSrc(reqSrc), .reqPrio(reqPrio),
    .opValid(opValid), .opCode(opCode), .opData(opData),
    .cppr(cppr), .xisr(xisr), .pendPrio(pendPrio), .mfrr(mfrr),
    .ownerValid(ownerValid), .ctl(ctl),
    .rejValid(rejValid), .rejSrc(rejSrc),
    .eoiValid(eoiValid), .eoiSrc(eoiSrc), .resendReq(resendReq)
  );

  intpres_dp #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqSrc(reqSrc), .reqPrio(reqPrio), .opData(opData),
    .cppr(cppr), .xisr(xisr), .pendPrio(pendPrio), .mfrr(mfrr),
    .ownerValid(ownerValid), .cpuIrq(cpuIrq)
  );

  assign regOut = {cppr, xisr};
  assign ipiOut = mfrr;

endmodule

// File: tb/intpres_top_tb_top.sv
module intpres_top_tb_top;

  localparam int SW = 24;
  localparam int PW = 8;
  localparam int RW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [SW-1:0] reqSrc = '0;
  logic [PW-1:0] reqPrio = '0;
  logic opValid = 1'b0;
  logic [2:0] opCode = '0;
  logic [RW-1:0] opData = '0;
  logic cpuIrq;
  logic [RW-1:0] regOut;
  logic [PW-1:0] ipiOut;
  logic rejValid;
  logic [SW-1:0] rejSrc;
  logic eoiValid;
  logic [SW-1:0] eoiSrc;
  logic resendReq;

  always #10 clk = ~clk;

  intpres_top dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqSrc(reqSrc), .reqPrio(reqPrio),
    .opValid(opValid), .opCode(opCode), .opData(opData),
    .cpuIrq(cpuIrq), .regOut(regOut), .ipiOut(ipiOut),
    .rejValid(rejValid), .rejSrc(rejSrc),
    .eoiValid(eoiValid), .eoiSrc(eoiSrc), .resendReq(resendReq)
  );

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  // behavioural model state
  logic [7:0]  mCppr, mPp, mMfrr;
  logic [23:0] mX;
  bit          mOwn, mIrq;
  bit          eRej, eEoi, eRes;
  logic [23:0] eRejSrc, eEoiSrc;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mIpiCheck();
    if (mX != 0 && mPp <= mMfrr) return;
    if (mX != 0 && mOwn) begin eRej = 1; eRejSrc = mX; end
    mX = 24'd2; mPp = mMfrr; mOwn = 0; mIrq = 1;
  endtask

  task automatic mResend();
    if (mMfrr < mCppr) mIpiCheck();
    eRes = 1;
  endtask

  // one request (isReq) or one operation, checked against the model
  task automatic step(input bit isReq, input logic [2:0] op, input logic [31:0] data,
                      input logic [23:0] src, input logic [7:0] prio);
    string tag;
    logic [7:0] oldC;
    @(negedge clk);
    reqValid = isReq; reqSrc = src; reqPrio = prio;
    opValid = !isReq; opCode = op; opData = data;
    #2;
    eRej = 0; eEoi = 0; eRes = 0; eRejSrc = 0; eEoiSrc = 0;
    if (isReq) begin
      if (prio >= mCppr || (mX != 0 && mPp <= prio)) begin
        tag = "R3"; eRej = 1; eRejSrc = src;
      end else begin
        tag = "R4";
        if (mX != 0 && mOwn) begin eRej = 1; eRejSrc = mX; end
        mX = src; mPp = prio; mOwn = 1; mIrq = 1;
      end
    end else begin
      case (op)
        3'd0: begin
          tag = "R5";
          chk("R5 accept value", regOut, {mCppr, mX});
          mCppr = mPp; mX = 0; mPp = 8'hFF; mOwn = 0; mIrq = 0;
        end
        3'd1: begin
          tag = "R9";
          chk("R9 poll reg", regOut, {mCppr, mX});
          chk("R9 poll ipi", {24'd0, ipiOut}, {24'd0, mMfrr});
        end
        3'd2: begin
          tag = "R6";
          oldC = mCppr; mCppr = data[31:24];
          if (data[31:24] < oldC) begin
            if (mX != 0 && data[31:24] <= mPp) begin
              if (mOwn) begin eRej = 1; eRejSrc = mX; end
              mX = 0; mPp = 8'hFF; mOwn = 0; mIrq = 0;
            end
          end else if (mX == 0) mResend();
        end
        3'd3: begin
          tag = "R7";
          mMfrr = data[7:0];
          if (mMfrr < mCppr) mIpiCheck();
        end
        default: begin
          tag = "R8";
          mCppr = data[31:24]; eEoi = 1; eEoiSrc = data[23:0];
          if (mX == 0) mResend();
        end
      endcase
    end
    chk({tag, " reject"}, {31'd0, rejValid}, {31'd0, eRej});
    if (eRej) chk({tag, " reject src"}, {8'd0, rejSrc}, {8'd0, eRejSrc});
    chk({tag, " eoi"}, {31'd0, eoiValid}, {31'd0, eEoi});
    if (eEoi) chk("R8 eoi src", {8'd0, eoiSrc}, {8'd0, eEoiSrc});
    chk({tag, " R10 resend"}, {31'd0, resendReq}, {31'd0, eRes});
    @(posedge clk);
    #2;
    reqValid = 0; opValid = 0;
    #1;
    chk({tag, " reg"}, regOut, {mCppr, mX});
    chk({tag, " ipi"}, {24'd0, ipiOut}, {24'd0, mMfrr});
    chk("R2 irq line", {31'd0, cpuIrq}, {31'd0, mIrq});
    chk("R10 pulses idle", {29'd0, rejValid, eoiValid, resendReq}, 32'd0);
  endtask

  logic [31:0] lcg = 32'h1234_5678;
  function automatic logic [7:0] pickPrio(input logic [31:0] r);
    return (r % 9 == 8) ? 8'hFF : 8'(r % 8);
  endfunction

  initial begin : watchdog
    #(20 * 150000);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    mCppr = 0; mX = 0; mPp = 8'hFF; mMfrr = 8'hFF; mOwn = 0; mIrq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R1 reset reg", regOut, 32'd0);
    chk("R1 reset ipi", {24'd0, ipiOut}, 32'hFF);
    chk("R1 reset irq", {31'd0, cpuIrq}, 32'd0);
    chk("R1 reset pulses", {29'd0, rejValid, eoiValid, resendReq}, 32'd0);

    // directed: request refused at priority 0
    step(1, 3'd0, 0, 24'd5, 8'd3);
    // IPI below current priority that is too favored: nothing happens
    step(0, 3'd3, 32'h0000_0005, 0, 0);
    // relax priority: resend then IPI with source 2
    step(0, 3'd2, 32'hFF00_0000, 0, 0);
    chk("R7 ipi source two", regOut, 32'hFF00_0002);
    // request displaces IPI: no reject (IPI has no owner)
    step(1, 3'd0, 0, 24'd9, 8'd3);
    chk("R7 ipi displaced reg", regOut, 32'hFF00_0009);
    // more favored request displaces sourced one: reject 9
    step(1, 3'd0, 0, 24'd11, 8'd1);
    // drop by current priority write
    step(0, 3'd2, 32'h0100_0000, 0, 0);
    chk("R6 dropped", regOut, 32'h0100_0000);
    // EOI restores 0xFF, resends, IPI returns
    step(0, 3'd4, 32'hFF00_000B, 0, 0);
    step(0, 3'd0, 0, 0, 0);
    chk("R5 accepted ipi prio", regOut, 32'h0500_0000);
    step(0, 3'd1, 0, 0, 0);

    // sweep: pseudo-random operations over small ranges
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      logic [7:0]  p;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      r = lcg >> 8;
      p = pickPrio(r >> 4);
      case (r % 8)
        0, 1, 2: step(1, 3'd0, 0, 24'(1 + (r >> 9) % 15), p);
        3: step(0, 3'd0, 0, 0, 0);
        4: step(0, 3'd2, {p, 24'd0}, 0, 0);
        5: step(0, 3'd3, {24'd0, p}, 0, 0);
        6: step(0, 3'd4, {p, 24'(1 + (r >> 13) % 15)}, 0, 0);
        default: step(0, 3'd1, 0, 0, 0);
      endcase
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule